// File: doc/BRIEF.md
# Flash Status Register with Sticky Error Flags

This block keeps the status byte that a flash write engine reports to its host. It collects error pulses from the engine into sticky flags. A flag stays set across any number of later operations until the host issues a clear-status strobe. The flag bits are erase error, program error, supply-voltage error and block-locked error. The same byte carries a ready/busy bit and a suspend bit.

The host reads the byte through an active-low output enable and a group of active-low chip enables. A read starts when the device is enabled and the output enable is low, and at least one of the two was not in that state in the previous cycle. At that point the block captures a snapshot of the status. The snapshot does not change for as long as the read continues. A fresh value can only be captured after the output enable goes high or the device is deselected.

While the snapshot shows the engine busy, only the ready bit is driven. All other bits have their per-bit output enable low. All pins are synchronous to `clk`. The command decoder and the array are not part of this block.

Top module: `fsr_status_unit`

## Requirements
- R1: While and after reset, with no read in progress, `stat_oe` and `stat_q` are 0. After reset the four error flags are clear, so the first ready read returns 8'h80.
- R2: A one-cycle pulse on an error input sets its flag. The flag positions are erase at bit 5, program at bit 4, supply voltage at bit 3 and block-locked at bit 1. The flag stays set through later busy/ready periods and later reads. Flags from different operations add together.
- R3: `clr_stb` clears all four flags when `eng_ready` is 1. It also clears them when `eng_suspended` is 1 and the engine is busy.
- R4: `clr_stb` has no effect when `eng_ready` is 0 and `eng_suspended` is 0.
- R5: If an error pulse and an accepted `clr_stb` arrive in the same cycle, that flag ends set and the other flags are cleared.
- R6: A read starts in a cycle where the device is enabled (every `ce_n` bit low) and `oe_n` is low, after a cycle in which either condition was false. The status is captured at that clock edge. `stat_q` and `stat_oe` show it from the next cycle on.
- R7: While the read continues, `stat_q` and `stat_oe` hold the captured value even if ready or the flags change. A new value is captured only after `oe_n` goes high or the device is deselected, followed by a new read.
- R8: With `oe_n` already low, the chip-enable edge that enables the device starts a read. With any `ce_n` bit high the device is disabled.
- R9: If the captured ready bit is 0 (busy), `stat_oe` is 8'h80 and `stat_q` is 8'h00.
- R10: If the captured ready bit is 1, `stat_oe` is 8'hFF. Bit 6 is `eng_suspended`, and bits 2 and 0 read 0.
- R11: One cycle after the read ends (oe_n high or device disabled), `stat_oe` and `stat_q` return to 0.
- R12: Bit 7 shows the live `eng_ready` value at the capture edge: 1 for ready, 0 for busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_ready | input | 1 | Engine ready (1) / busy (0) |
| eng_suspended | input | 1 | Engine operation suspended |
| err_erase_p | input | 1 | Erase failure pulse |
| err_prog_p | input | 1 | Program failure pulse |
| err_vpp_p | input | 1 | Supply-voltage failure pulse |
| err_lock_p | input | 1 | Locked-block attempt pulse |
| clr_stb | input | 1 | Clear-status strobe |
| oe_n | input | 1 | Active-low output enable |
| ce_n | input | NUM_CE | Active-low chip enables, all low to enable |
| stat_q | output | 8 | Status byte, undriven bits forced to 0 |
| stat_oe | output | 8 | Per-bit output-valid enables |

## Verification
An error pulse or a clear at clock edge k changes the flags at edge k. A read started afterwards sees the change. The capture edge is the first edge at which the read condition holds, and the outputs show the captured value one cycle later. The end of a read clears the outputs one cycle after its edge. The bench drives inputs on the falling clock edge and checks on the next falling edge, which comes after exactly one rising edge. Hold checks wait several cycles with the read still in progress, and each check is placed on the cycle where its result is due.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int STAT_W   = 8;
   localparam int NUM_ERR  = 4;
   localparam int POS_RDY  = 7;
   localparam int POS_SUSP = 6;
   localparam int POS_ERS  = 5;
   localparam int POS_PRG  = 4;
   localparam int POS_VPP  = 3;
   localparam int POS_RSV2 = 2;
   localparam int POS_LCK  = 1;
   localparam int POS_RSV0 = 0;

   // flag vector order: [3]=erase [2]=program [1]=supply [0]=locked
   localparam int FI_ERS = 3;
   localparam int FI_PRG = 2;
   localparam int FI_VPP = 1;
   localparam int FI_LCK = 0;

   typedef logic [STAT_W-1:0]  stat_t;
   typedef logic [NUM_ERR-1:0] flags_t;

   function automatic stat_t build_status(input logic rdy, input logic susp,
                                          input flags_t f);
      stat_t s;
      s           = '0;
      s[POS_RDY]  = rdy;
      s[POS_SUSP] = susp;
      s[POS_ERS]  = f[FI_ERS];
      s[POS_PRG]  = f[FI_PRG];
      s[POS_VPP]  = f[FI_VPP];
      s[POS_LCK]  = f[FI_LCK];
      s[POS_RSV2] = 1'b0;
      s[POS_RSV0] = 1'b0;
      return s;
   endfunction
endpackage

// File: rtl/fsr_sticky_flags.sv
module fsr_sticky_flags #(
   parameter int N_FLAGS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] set_p,
   input  logic               clr_ok,
   output logic [N_FLAGS-1:0] flags
);
   generate
      if (N_FLAGS < 1) begin : g_bad_n
         $error("fsr_sticky_flags: N_FLAGS must be at least 1");
      end
      for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)          flags[i] <= 1'b0;
            else if (set_p[i])   flags[i] <= 1'b1;   // set beats clear
            else if (clr_ok)     flags[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/fsr_read_latch.sv
module fsr_read_latch #(
   parameter int NUM_CE      = 3,
   parameter bit CE_EDGE_ARM = 1'b1,
   parameter int W           = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              oe_n,
   input  logic [NUM_CE-1:0] ce_n,
   input  logic [W-1:0]      live,
   output logic              dev_en,
   output logic              rd_q,
   output logic [W-1:0]      snap_q
);
   logic reading;
   logic armed_q;
   logic arm_next;
   logic capture;

   generate
      if (NUM_CE < 1) begin : g_bad_ce
         $error("fsr_read_latch: NUM_CE must be at least 1");
      end
      if (NUM_CE == 1) begin : g_one_ce
         assign dev_en = ~ce_n[0];
      end else begin : g_multi_ce
         assign dev_en = ~(|ce_n);
      end
      if (CE_EDGE_ARM) begin : g_arm_any
         // re-armed by output-enable release or by deselect
         assign arm_next = ~reading;
      end else begin : g_arm_oe
         // re-armed only by output-enable release
         assign arm_next = oe_n;
      end
   endgenerate

   assign reading = dev_en & ~oe_n;
   assign capture = reading & armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         rd_q    <= 1'b0;
         snap_q  <= '0;
      end else begin
         armed_q <= arm_next;
         rd_q    <= reading;
         if (capture) snap_q <= live;
      end
   end
endmodule

// File: rtl/fsr_drive_mask.sv
module fsr_drive_mask #(
   parameter int W       = 8,
   parameter int RDY_POS = 7
) (
   input  logic         rd_q,
   input  logic [W-1:0] snap_q,
   output logic [W-1:0] stat_q,
   output logic [W-1:0] stat_oe
);
   localparam logic [W-1:0] ALL_ON  = {W{1'b1}};
   localparam logic [W-1:0] RDY_ONE = W'(1) << RDY_POS;

   generate
      if (RDY_POS >= W) begin : g_bad_pos
         $error("fsr_drive_mask: RDY_POS outside the status width");
      end
   endgenerate

   always_comb begin
      if (!rd_q)                stat_oe = '0;
      else if (snap_q[RDY_POS]) stat_oe = ALL_ON;
      else                      stat_oe = RDY_ONE;
      stat_q = snap_q & stat_oe;
   end
endmodule

// File: rtl/fsr_status_unit.sv
module fsr_status_unit
   import fsr_pkg::*;
#(
   parameter int NUM_CE          = 3,
   parameter bit CE_EDGE_ARM     = 1'b1,
   parameter bit CLR_IN_SUSPEND  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_ready,
   input  logic              eng_suspended,
   input  logic              err_erase_p,
   input  logic              err_prog_p,
   input  logic              err_vpp_p,
   input  logic              err_lock_p,
   input  logic              clr_stb,
   input  logic              oe_n,
   input  logic [NUM_CE-1:0] ce_n,
   output logic [7:0]        stat_q,
   output logic [7:0]        stat_oe
);
   generate
      if (STAT_W != 8) begin : g_bad_w
         $error("fsr_status_unit: status width must be 8");
      end
   endgenerate

   flags_t err_pulse;
   flags_t err_flags;
   logic   clr_ok;
   stat_t  live;
   stat_t  snap_q;
   logic   rd_q;
   logic   dev_en;

   assign err_pulse[FI_ERS] = err_erase_p;
   assign err_pulse[FI_PRG] = err_prog_p;
   assign err_pulse[FI_VPP] = err_vpp_p;
   assign err_pulse[FI_LCK] = err_lock_p;

   generate
      if (CLR_IN_SUSPEND) begin : g_clr_susp
         assign clr_ok = clr_stb & (eng_ready | eng_suspended);
      end else begin : g_clr_idle
         assign clr_ok = clr_stb & eng_ready;
      end
   endgenerate

   fsr_sticky_flags #(.N_FLAGS(NUM_ERR)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_p  (err_pulse),
      .clr_ok (clr_ok),
      .flags  (err_flags)
   );

   assign live = build_status(eng_ready, eng_suspended, err_flags);

   fsr_read_latch #(.NUM_CE(NUM_CE), .CE_EDGE_ARM(CE_EDGE_ARM), .W(STAT_W)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .oe_n   (oe_n),
      .ce_n   (ce_n),
      .live   (live),
      .dev_en (dev_en),
      .rd_q   (rd_q),
      .snap_q (snap_q)
   );

   fsr_drive_mask #(.W(STAT_W), .RDY_POS(POS_RDY)) u_mask (
      .rd_q    (rd_q),
      .snap_q  (snap_q),
      .stat_q  (stat_q),
      .stat_oe (stat_oe)
   );
endmodule

module fsr_status_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       eng_ready,
   input logic       eng_suspended,
   input logic       clr_stb,
   input logic       oe_n,
   input logic       dev_en,
   input logic [3:0] err_pulse,
   input logic [3:0] err_flags,
   input logic [7:0] stat_q,
   input logic [7:0] stat_oe
);
   // R2
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_pulse) |=> ((err_flags & $past(err_pulse)) == $past(err_pulse)));

   // R4
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_stb && (eng_ready || eng_suspended)) |=>
         ((err_flags & $past(err_flags)) == $past(err_flags)));

   // R11
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_en && !oe_n) |=> (stat_oe == 8'h00 && stat_q == 8'h00));

   // R9
   busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_oe[7] && !stat_q[7]) |-> (stat_oe == 8'h80 && stat_q == 8'h00));

   // R10
   ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_oe[7] && stat_q[7]) |-> (stat_oe == 8'hFF && !stat_q[2] && !stat_q[0]));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_en && !oe_n && stat_oe[7]) |=> ($stable(stat_q) && $stable(stat_oe)));
endmodule

bind fsr_status_unit fsr_status_unit_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .eng_ready     (eng_ready),
   .eng_suspended (eng_suspended),
   .clr_stb       (clr_stb),
   .oe_n          (oe_n),
   .dev_en        (dev_en),
   .err_pulse     (err_pulse),
   .err_flags     (err_flags),
   .stat_q        (stat_q),
   .stat_oe       (stat_oe)
);

// File: tb/fsr_status_unit_tb.sv
module fsr_status_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       eng_ready = 1'b1;
   logic       eng_suspended = 1'b0;
   logic       err_erase_p = 1'b0;
   logic       err_prog_p = 1'b0;
   logic       err_vpp_p = 1'b0;
   logic       err_lock_p = 1'b0;
   logic       clr_stb = 1'b0;
   logic       oe_n = 1'b1;
   logic [2:0] ce_n = 3'b000;
   logic [7:0] stat_q;
   logic [7:0] stat_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   fsr_status_unit #(.NUM_CE(3)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .eng_ready     (eng_ready),
      .eng_suspended (eng_suspended),
      .err_erase_p   (err_erase_p),
      .err_prog_p    (err_prog_p),
      .err_vpp_p     (err_vpp_p),
      .err_lock_p    (err_lock_p),
      .clr_stb       (clr_stb),
      .oe_n          (oe_n),
      .ce_n          (ce_n),
      .stat_q        (stat_q),
      .stat_oe       (stat_oe)
   );

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] q_exp, input logic [7:0] oe_exp);
      checks++;
      if (stat_q !== q_exp || stat_oe !== oe_exp) begin
         errors++;
         $display("FAIL %s: stat_q=%h stat_oe=%h expected stat_q=%h stat_oe=%h",
                  tag, stat_q, stat_oe, q_exp, oe_exp);
      end
   endtask

   // full read: start, check one cycle later, release, check quiet
   task automatic read_expect(input string tag, input logic [7:0] q_exp, input logic [7:0] oe_exp);
      oe_n = 1'b0;
      step();
      chk(tag, q_exp, oe_exp);
      oe_n = 1'b1;
      step();
      chk({tag, " R11 release"}, 8'h00, 8'h00);
   endtask

   task automatic pulse(input int which);
      case (which)
         5: err_erase_p = 1'b1;
         4: err_prog_p  = 1'b1;
         3: err_vpp_p   = 1'b1;
         default: err_lock_p = 1'b1;
      endcase
      step();
      err_erase_p = 1'b0; err_prog_p = 1'b0; err_vpp_p = 1'b0; err_lock_p = 1'b0;
   endtask

   task automatic clear_pulse();
      clr_stb = 1'b1;
      step();
      clr_stb = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      step(3);
      chk("R1 in reset", 8'h00, 8'h00);
      rst_n = 1'b1;
      step();
      chk("R1 after reset", 8'h00, 8'h00);
      read_expect("R1 R10 R12 first ready read", 8'h80, 8'hFF);
   endtask

   task automatic t_busy();
      eng_ready = 1'b0;
      step();
      read_expect("R9 R12 busy read", 8'h00, 8'h80);
      eng_ready = 1'b1;
      step();
   endtask

   task automatic t_accumulate();
      pulse(5);
      eng_ready = 1'b0; step(3); eng_ready = 1'b1; step();
      read_expect("R2 erase flag", 8'hA0, 8'hFF);
      pulse(4);
      read_expect("R2 erase+program", 8'hB0, 8'hFF);
      eng_ready = 1'b0; step(2); pulse(3); eng_ready = 1'b1; step();
      read_expect("R2 plus supply", 8'hB8, 8'hFF);
      pulse(1);
      step(4);
      read_expect("R2 all four", 8'hBA, 8'hFF);
   endtask

   task automatic t_clear();
      clear_pulse();
      read_expect("R3 clear when ready", 8'h80, 8'hFF);
      pulse(5); pulse(1);
      eng_ready = 1'b0; eng_suspended = 1'b0;
      clear_pulse();
      eng_ready = 1'b1;
      step();
      read_expect("R4 clear while busy ignored", 8'hA2, 8'hFF);
      eng_ready = 1'b0; eng_suspended = 1'b1;
      clear_pulse();
      eng_ready = 1'b1;
      step();
      read_expect("R3 R10 clear while suspended, bit6", 8'hC0, 8'hFF);
      eng_suspended = 1'b0;
      step();
   endtask

   task automatic t_collide();
      pulse(5); pulse(3);
      err_prog_p = 1'b1;
      clr_stb    = 1'b1;
      step();
      err_prog_p = 1'b0;
      clr_stb    = 1'b0;
      read_expect("R5 pulse beats clear", 8'h90, 8'hFF);
      clear_pulse();
   endtask

   task automatic t_hold();
      eng_ready = 1'b0;
      step();
      oe_n = 1'b0;
      step();
      chk("R6 capture next cycle", 8'h00, 8'h80);
      eng_ready = 1'b1;
      pulse(4);
      step(3);
      chk("R7 held while reading", 8'h00, 8'h80);
      oe_n = 1'b1;
      step();
      chk("R11 after release", 8'h00, 8'h00);
      read_expect("R7 refresh after release", 8'h90, 8'hFF);
      clear_pulse();
   endtask

   task automatic t_ce_edge();
      ce_n = 3'b010;
      oe_n = 1'b0;
      step(2);
      chk("R8 R11 one enable high disables", 8'h00, 8'h00);
      ce_n = 3'b000;
      step();
      chk("R8 enable edge captures", 8'h80, 8'hFF);
      eng_ready = 1'b0;
      step(2);
      chk("R7 held on stale ready", 8'h80, 8'hFF);
      ce_n = 3'b100;
      step();
      chk("R11 deselect quiets", 8'h00, 8'h00);
      ce_n = 3'b000;
      step();
      chk("R8 R12 reselect refreshes busy", 8'h00, 8'h80);
      oe_n = 1'b1;
      eng_ready = 1'b1;
      step();
      chk("R11 end", 8'h00, 8'h00);
   endtask

   initial begin
      step();
      t_reset();
      t_busy();
      t_accumulate();
      t_clear();
      t_collide();
      t_hold();
      t_ce_edge();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule